// File: doc/BRIEF.md
# Split-Word Pad Output Data Register

This block holds the output values driven toward 38 management-owned pads and returns the live pad input levels on reads. Two write sources reach it. The first is a 32-bit bus with four byte enables and a word select. It reaches a low word covering pads 0 to 31 and a high word covering pads 32 to 37. The second is a byte-wide serial-port path that addresses five bytes one at a time.

A low-word bus write is committed to the pads only when it carries the most significant byte lane. A low-word write without that lane is parked in a per-lane staging register. It lands on the pads, merged with the newly written lanes, when a later write brings the top lane. Reads never return stored output data. They return the level seen at the pad, so software observes the pin and not the latch.

Top module: `gpio_word_reg`

## Requirements
- R1: While reset is asserted, and after it is released, every pad output is 0 and the staging register holds no pending lanes. A top-lane-only low write after reset therefore leaves pads 0 to 23 at 0.
- R2: `bus_rdata` with `bus_sel_hi`=0 equals `pad_in[31:0]` in the same cycle, whatever values were written.
- R3: `bus_rdata` with `bus_sel_hi`=1 equals `pad_in[37:32]` in bits 5:0, with bits 31:6 reading 0.
- R4: A low-word bus write (`bus_sel_hi`=0) with `bus_be[3]`=1 updates pads 0 to 31 together at the next clock edge. Byte lane k (bits 8k+7:8k) takes the new data if `bus_be[k]`=1, else the staged byte if lane k is pending, else keeps its value.
- R5: A low-word bus write with `bus_be[3]`=0 leaves every pad output unchanged. It stores each enabled lane into staging and marks that lane pending.
- R6: A committing low-word write clears all pending marks, so a following top-lane-only write does not reapply earlier staged bytes.
- R7: A high-word bus write with `bus_be[0]`=1 sets pads 32 to 37 to `bus_wdata[5:0]` together and leaves pads 0 to 31 alone. With `bus_be[0]`=0 it changes nothing.
- R8: A serial write changes exactly one byte. Address 0 sets pads 37 to 32 from `ser_wdata[5:0]`. Addresses 1, 2, 3 and 4 set pads 31:24, 23:16, 15:8 and 7:0. Addresses 5 to 7 change nothing.
- R9: `ser_rdata` returns the pad levels of the byte selected by `ser_addr` under the R8 mapping, with unused bits 0 and addresses 5 to 7 reading 0.
- R10: When `bus_we` and `ser_we` are both high in a cycle, the bus write is applied and the serial write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Bus write strobe |
| bus_sel_hi | input | 1 | Word select: 0 low word, 1 high word |
| bus_be | input | 4 | Bus byte enables |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Pad levels of the selected word |
| ser_we | input | 1 | Serial-path byte write strobe |
| ser_addr | input | 3 | Serial-path byte address |
| ser_wdata | input | 8 | Serial-path write data |
| ser_rdata | output | 8 | Pad levels of the addressed byte |
| pad_in | input | 38 | Live pad input levels |
| pad_out | output | 38 | Output values toward the pads |

## Verification
The bench builds the block with its default 38 pads and a 32-bit word, which gives four low lanes and one short high byte. That is small enough to sweep every partial byte-enable pattern against every committing pattern. So each staging-then-merge combination, and the clearing of pending lanes after it, is checked against an arithmetic model. All eight serial addresses are also swept, including the three unmapped ones, and both write sources are raised in the same cycle.

// File: rtl/gpw_pkg.sv
package gpw_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  // Per-lane merge: new data wins, then a pending staged byte, then the old value.
  function automatic logic [WORD_W-1:0] lane_merge(
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] stg,
    input logic [LANES-1:0]  pend,
    input logic [WORD_W-1:0] nw,
    input logic [LANES-1:0]  be
  );
    logic [WORD_W-1:0] r;
    r = cur;
    for (int l = 0; l < LANES; l++) begin
      if (be[l])        r[8*l +: 8] = nw[8*l +: 8];
      else if (pend[l]) r[8*l +: 8] = stg[8*l +: 8];
    end
    return r;
  endfunction

  // Serial byte address of low-word lane l (address 0 is the high word).
  function automatic int lane_ser_addr(input int l);
    return LANES - l;
  endfunction
endpackage

// File: rtl/gpw_stage.sv
module gpw_stage
  import gpw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stage_en,
  input  logic              clear,
  input  logic [LANES-1:0]  be,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] stg_q,
  output logic [LANES-1:0]  pend_q
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg_q[8*l +: 8] <= '0;
        pend_q[l]       <= 1'b0;
      end else if (clear) begin
        pend_q[l]       <= 1'b0;
      end else if (stage_en && be[l]) begin
        stg_q[8*l +: 8] <= wdata[8*l +: 8];
        pend_q[l]       <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpw_outreg.sv
module gpw_outreg
  import gpw_pkg::*;
#(
  parameter int NPADS  = 38,
  parameter int SER_AW = 3,
  localparam int HI_W  = NPADS - WORD_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_commit,
  input  logic [WORD_W-1:0] lo_val,
  input  logic              hi_commit,
  input  logic [HI_W-1:0]   hi_val,
  input  logic              ser_commit,
  input  logic [SER_AW-1:0] ser_addr,
  input  logic [7:0]        ser_byte,
  output logic [NPADS-1:0]  pad_out
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [SER_AW-1:0] MY_ADDR = SER_AW'(lane_ser_addr(l));
    always_ff @(posedge clk) begin
      if (!rst_n)
        pad_out[8*l +: 8] <= '0;
      else if (lo_commit)
        pad_out[8*l +: 8] <= lo_val[8*l +: 8];
      else if (ser_commit && ser_addr == MY_ADDR)
        pad_out[8*l +: 8] <= ser_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pad_out[NPADS-1:WORD_W] <= '0;
    else if (hi_commit)
      pad_out[NPADS-1:WORD_W] <= hi_val;
    else if (ser_commit && ser_addr == '0)
      pad_out[NPADS-1:WORD_W] <= ser_byte[HI_W-1:0];
  end
endmodule

// File: rtl/gpw_rdmux.sv
module gpw_rdmux
  import gpw_pkg::*;
#(
  parameter int NPADS  = 38,
  parameter int SER_AW = 3,
  localparam int HI_W  = NPADS - WORD_W
)(
  input  logic [NPADS-1:0]  pad_in,
  input  logic              sel_hi,
  input  logic [SER_AW-1:0] ser_addr,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [7:0]        ser_rdata
);
  logic [7:0] hi_byte;
  assign hi_byte   = 8'(pad_in[NPADS-1:WORD_W]);
  assign bus_rdata = sel_hi ? WORD_W'(pad_in[NPADS-1:WORD_W]) : pad_in[WORD_W-1:0];

  always_comb begin
    ser_rdata = '0;
    if (ser_addr == '0) ser_rdata = hi_byte;
    for (int l = 0; l < LANES; l++)
      if (ser_addr == SER_AW'(lane_ser_addr(l))) ser_rdata = pad_in[8*l +: 8];
  end
endmodule

// File: rtl/gpio_word_reg.sv
module gpio_word_reg
  import gpw_pkg::*;
#(
  parameter int NPADS  = 38,
  parameter int SER_AW = 3,
  localparam int HI_W  = NPADS - WORD_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_sel_hi,
  input  logic [LANES-1:0]  bus_be,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              ser_we,
  input  logic [SER_AW-1:0] ser_addr,
  input  logic [7:0]        ser_wdata,
  output logic [7:0]        ser_rdata,
  input  logic [NPADS-1:0]  pad_in,
  output logic [NPADS-1:0]  pad_out
);
  // Named events, visible to the bound checker.
  logic lo_wr, ev_lo_commit, ev_lo_stage, ev_hi_commit, ev_ser_commit;
  logic [WORD_W-1:0] stg_q, lo_val;
  logic [LANES-1:0]  pend_q;

  assign lo_wr         = bus_we && !bus_sel_hi;
  assign ev_lo_commit  = lo_wr && bus_be[LANES-1];
  assign ev_lo_stage   = lo_wr && !bus_be[LANES-1];
  assign ev_hi_commit  = bus_we && bus_sel_hi && bus_be[0];
  assign ev_ser_commit = ser_we && !bus_we && (int'(ser_addr) <= LANES);
  assign lo_val        = lane_merge(pad_out[WORD_W-1:0], stg_q, pend_q, bus_wdata, bus_be);

  gpw_stage u_stage (
    .clk(clk), .rst_n(rst_n), .stage_en(ev_lo_stage), .clear(ev_lo_commit),
    .be(bus_be), .wdata(bus_wdata), .stg_q(stg_q), .pend_q(pend_q)
  );

  gpw_outreg #(.NPADS(NPADS), .SER_AW(SER_AW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .lo_commit(ev_lo_commit), .lo_val(lo_val),
    .hi_commit(ev_hi_commit), .hi_val(bus_wdata[HI_W-1:0]),
    .ser_commit(ev_ser_commit), .ser_addr(ser_addr), .ser_byte(ser_wdata),
    .pad_out(pad_out)
  );

  gpw_rdmux #(.NPADS(NPADS), .SER_AW(SER_AW)) u_rd (
    .pad_in(pad_in), .sel_hi(bus_sel_hi), .ser_addr(ser_addr),
    .bus_rdata(bus_rdata), .ser_rdata(ser_rdata)
  );
endmodule

// File: rtl/gpio_word_reg_chk.sv
module gpio_word_reg_chk #(
  parameter int NPADS  = 38,
  parameter int SER_AW = 3
)(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [SER_AW-1:0] ser_addr,
  input logic              ser_we,
  input logic [NPADS-1:0]  pad_out,
  input logic              ev_lo_commit,
  input logic              ev_lo_stage,
  input logic              ev_hi_commit,
  input logic              ev_ser_commit
);
  // R5: a partial low write leaves every output untouched
  a_r5_partial_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lo_stage |=> $stable(pad_out));

  // R4: top lane of a committing write always lands on the pads
  a_r4_top_lane: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lo_commit |=> pad_out[31:24] == $past(bus_wdata[31:24]));

  // R7: high-word commit sets pads 32+ and spares the low word
  a_r7_hi_value: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hi_commit |=> pad_out[NPADS-1:32] == $past(bus_wdata[NPADS-33:0]));
  a_r7_hi_spares_lo: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hi_commit |=> $stable(pad_out[31:0]));

  // R10: a bus write blocks the serial path
  a_r10_bus_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && ser_we) |-> !ev_ser_commit);

  // R8: serial write to address 4 touches only pads 7..0
  a_r8_one_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ser_commit && ser_addr == SER_AW'(4)) |=> $stable(pad_out[NPADS-1:8]));

  // R1: no activity at all keeps outputs steady
  a_r1_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_lo_commit && !ev_hi_commit && !ev_ser_commit) |=> $stable(pad_out));
endmodule

bind gpio_word_reg gpio_word_reg_chk #(.NPADS(NPADS), .SER_AW(SER_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .ser_addr(ser_addr), .ser_we(ser_we), .pad_out(pad_out),
  .ev_lo_commit(ev_lo_commit), .ev_lo_stage(ev_lo_stage),
  .ev_hi_commit(ev_hi_commit), .ev_ser_commit(ev_ser_commit)
);

// File: tb/gpio_word_reg_test.sv
module gpio_word_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0, bus_sel_hi = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        ser_we = 1'b0;
  logic [2:0]  ser_addr = '0;
  logic [7:0]  ser_wdata = '0, ser_rdata;
  logic [37:0] pad_in = '0, pad_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [37:0] m_out  = '0;
  logic [31:0] m_stg  = '0;
  logic [3:0]  m_pend = '0;

  always #4 clk = ~clk;

  gpio_word_reg uut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic m_bus(bit hi, logic [3:0] be, logic [31:0] d);
    if (hi) begin
      if (be[0]) m_out[37:32] = d[5:0];
    end else if (be[3]) begin
      for (int l = 0; l < 4; l++)
        if (be[l]) m_out[8*l +: 8] = d[8*l +: 8];
        else if (m_pend[l]) m_out[8*l +: 8] = m_stg[8*l +: 8];
      m_pend = '0;
    end else begin
      for (int l = 0; l < 4; l++)
        if (be[l]) begin m_stg[8*l +: 8] = d[8*l +: 8]; m_pend[l] = 1'b1; end
    end
  endtask

  task automatic m_ser(int a, logic [7:0] d);
    if (a == 0) m_out[37:32] = d[5:0];
    else if (a <= 4) m_out[8*(4-a) +: 8] = d;
  endtask

  task automatic bus_wr(bit hi, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_sel_hi = hi; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    m_bus(hi, be, d);
  endtask

  task automatic ser_wr(int a, logic [7:0] d);
    @(negedge clk);
    ser_we = 1'b1; ser_addr = 3'(a); ser_wdata = d;
    @(negedge clk);
    ser_we = 1'b0;
    m_ser(a, d);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    m_out = '0; m_stg = '0; m_pend = '0;
  endtask

  function automatic logic [7:0] exp_ser_rd(int a, logic [37:0] p);
    if (a == 0) return {2'b00, p[37:32]};
    if (a <= 4) return p[8*(4-a) +: 8];
    return 8'h00;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 reset outputs", 64'(pad_out), 64'h0);

    // R2/R3/R9: reads follow the pads, not the written data
    bus_wr(0, 4'hF, 32'hFFFF_FFFF);
    for (int k = 0; k < 4; k++) begin
      logic [37:0] p;
      p = {6'(k * 13 + 5), 32'hC3A5_0F01 ^ (32'h1111_1111 * k)};
      pad_in = p;
      bus_sel_hi = 1'b0; #1;
      check("R2 low read", 64'(bus_rdata), 64'(p[31:0]));
      bus_sel_hi = 1'b1; #1;
      check("R3 high read", 64'(bus_rdata), 64'(p[37:32]));
      for (int a = 0; a < 8; a++) begin
        ser_addr = 3'(a); #1;
        check("R9 serial read", 64'(ser_rdata), 64'(exp_ser_rd(a, p)));
      end
    end
    bus_sel_hi = 1'b0;

    // R4/R5/R6: every partial pattern against every committing pattern
    for (int p = 0; p < 8; p++)
      for (int c = 8; c < 16; c++) begin
        bus_wr(0, 4'hF, 32'h5A5A_5A5A ^ (32'h0101_0101 * (p + c)));
        bus_wr(0, 4'(p), 32'h1357_9BDF + 32'(p * 977));
        check("R5 partial no change", 64'(pad_out), 64'(m_out));
        bus_wr(0, 4'(c), 32'hE1D2_C3B4 ^ 32'(c * 40503));
        check("R4 commit merge", 64'(pad_out), 64'(m_out));
        bus_wr(0, 4'h8, 32'h7700_0000 + 32'(c));
        check("R6 pending cleared", 64'(pad_out), 64'(m_out));
      end

    // R7: high word with and without lane 0
    bus_wr(1, 4'h1, 32'hFFFF_FF2B);
    check("R7 hi commit", 64'(pad_out), 64'(m_out));
    bus_wr(1, 4'hE, 32'h0000_0015);
    check("R7 hi ignored without lane 0", 64'(pad_out), 64'(m_out));

    // R8: every serial address
    for (int a = 0; a < 8; a++) begin
      ser_wr(a, 8'h3C ^ 8'(a * 37));
      check("R8 serial byte", 64'(pad_out), 64'(m_out));
    end

    // R10: both sources in one cycle
    @(negedge clk);
    bus_we = 1'b1; bus_sel_hi = 1'b0; bus_be = 4'hF; bus_wdata = 32'h0BAD_F00D;
    ser_we = 1'b1; ser_addr = 3'd4; ser_wdata = 8'h99;
    @(negedge clk);
    bus_we = 1'b0; ser_we = 1'b0;
    m_bus(0, 4'hF, 32'h0BAD_F00D);
    check("R10 bus wins", 64'(pad_out), 64'(m_out));

    // R1: reset discards pending lanes
    bus_wr(0, 4'h7, 32'h00AB_CDEF);
    do_reset();
    check("R1 reset outputs again", 64'(pad_out), 64'h0);
    bus_wr(0, 4'h8, 32'h4200_0000);
    check("R1 stage discarded", 64'(pad_out), 64'h0000_0042_000000 >> 0 & 64'h0_4200_0000);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule